// File: doc/BRIEF.md
# Receiver power mode controller

This block sequences the power modes of a serial-link receiver. It watches an active-low shutdown pin and a link-detect flag from the clock-lane common-mode monitor. From these it selects one of three modes: off, idle and run. In off, every piece of receive logic is held in reset and the configuration is cleared. In idle, the link monitor keeps watching but the deserializer stays in reset and the parallel outputs are held at their initial low value. In run, the deserializer is released. The parallel outputs are enabled only after a lock-wait interval has expired.

The lane-count and PLL-bandwidth pins are quasi-static. The system keeps them steady around a shutdown release, so the block captures them on that cycle and holds them until the next release. Both asynchronous inputs pass through a two-flop synchronizer. The link flag is then debounced, so short glitches on the detector never change the mode. A lane code that names no valid format keeps the block in idle and raises an error flag.

Top module: `rx_pwr_mode_ctrl`

## Requirements
- R1: Mode encoding on `mode_o`: 2'b00 off, 2'b01 idle, 2'b10 run. After reset, and 3 clock edges after `shdn_ni` falls from any mode, the mode is off with `core_rst_no`=0, `out_en_o`=0, `lane_cfg_o`=0, `bw_cfg_o`=0 and `cfg_err_o`=0.
- R2: 3 edges after `shdn_ni` rises, the mode goes from off to idle, and `out_en_o` and `core_rst_no` stay low.
- R3: With the block in idle (or being released) and `link_det_i` held high, the mode becomes run DEB_CYC+3 edges after `link_det_i` rises, or after `shdn_ni` rises if the link was already high. A link pulse shorter than DEB_CYC cycles never causes run.
- R4: `core_rst_no` is high exactly when the mode is run. `out_en_o` rises exactly LOCK_CYC edges after run is entered and is never high outside run.
- R5: When `link_det_i` falls while in run, the mode returns to idle DEB_CYC+3 edges later, and `out_en_o` drops on that same edge.
- R6: `lane_cfg_o` and `bw_cfg_o` take the values of `lane_sel_i` and `pll_bw_i` on the edge that leaves off. Later input changes are ignored until the next release.
- R7: A captured lane code of 2'b11 sets `cfg_err_o`, and the block stays in idle while the link is present. The flag clears in off.
- R8: If a shutdown and a debounced link arrival reach the mode logic on the same edge, shutdown wins and run is never entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shdn_ni | input | 1 | Shutdown pin, low requests off |
| link_det_i | input | 1 | Clock-lane common mode present (asynchronous) |
| lane_sel_i | input | 2 | Lane-count code, 2'b11 invalid |
| pll_bw_i | input | BW_W | PLL bandwidth select |
| mode_o | output | 2 | Current mode |
| core_rst_no | output | 1 | Deserializer reset, active low |
| out_en_o | output | 1 | Parallel output enable, low forces outputs low |
| lane_cfg_o | output | 2 | Captured lane-count code |
| bw_cfg_o | output | BW_W | Captured PLL bandwidth |
| cfg_err_o | output | 1 | Captured lane code is invalid |

## Verification
Shutdown and a freshly debounced link can reach the mode register on the same edge. The link filter needs DEB_CYC+2 edges and the shutdown path needs two, so the bench drives `shdn_ni` low exactly DEB_CYC cycles after raising `link_det_i`. It then watches `mode_o` on every cycle. The case passes only if run never appears and off is reached on the third edge after the shutdown drive.

// File: rtl/rxpm_pkg.sv
`timescale 1ns/1ps
package rxpm_pkg;
  localparam int LANE_W = 2;
  localparam logic [LANE_W-1:0] LANE_BAD = 2'b11;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_IDLE = 2'b01,
    MODE_RUN  = 2'b10
  } mode_e;
endpackage

// File: rtl/rxpm_sync.sv
`timescale 1ns/1ps
module rxpm_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/rxpm_debounce.sv
`timescale 1ns/1ps
module rxpm_debounce #(
  parameter int CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          q_q;

  // q follows d only after d has differed from q for CYC cycles in a row
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      q_q   <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      q_q   <= 1'b0;
    end else if (d_i == q_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      q_q   <= d_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/rxpm_lock_timer.sv
`timescale 1ns/1ps
module rxpm_lock_timer #(
  parameter int CYC = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == LAST) done_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/rx_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module rx_pwr_mode_ctrl
  import rxpm_pkg::*;
#(
  parameter int DEB_CYC  = 4,
  parameter int LOCK_CYC = 1024,
  parameter int BW_W     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shdn_ni,
  input  logic              link_det_i,
  input  logic [LANE_W-1:0] lane_sel_i,
  input  logic [BW_W-1:0]   pll_bw_i,
  output logic [1:0]        mode_o,
  output logic              core_rst_no,
  output logic              out_en_o,
  output logic [LANE_W-1:0] lane_cfg_o,
  output logic [BW_W-1:0]   bw_cfg_o,
  output logic              cfg_err_o
);
  logic [1:0] sync_d, sync_q;
  logic       shdn_s, link_s, link_ok, lock_done;
  mode_e      st_q, st_d;

  logic [LANE_W-1:0] lane_q;
  logic [BW_W-1:0]   bw_q;
  logic              err_q, run_q;

  assign sync_d = {shdn_ni, link_det_i};

  rxpm_sync #(.W(2), .RST_VAL(2'b00)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sync_d),
    .q_o   (sync_q)
  );

  assign shdn_s = sync_q[1];
  assign link_s = sync_q[0];

  // filter held cleared while shutdown is requested
  rxpm_debounce #(.CYC(DEB_CYC)) u_deb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (~shdn_s),
    .d_i   (link_s),
    .q_o   (link_ok)
  );

  rxpm_lock_timer #(.CYC(LOCK_CYC)) u_lock (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (st_q == MODE_RUN),
    .done_o(lock_done)
  );

  // shutdown has priority over every link event
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      MODE_OFF:  if (shdn_s) st_d = MODE_IDLE;
      MODE_IDLE: begin
        if (!shdn_s)                st_d = MODE_OFF;
        else if (link_ok && !err_q) st_d = MODE_RUN;
      end
      MODE_RUN: begin
        if (!shdn_s)      st_d = MODE_OFF;
        else if (!link_ok) st_d = MODE_IDLE;
      end
      default: st_d = MODE_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= MODE_OFF;
      run_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      run_q <= (st_d == MODE_RUN);
    end
  end

  // configuration: captured on the release edge, cleared on entry to off
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_q <= '0;
      bw_q   <= '0;
      err_q  <= 1'b0;
    end else if (st_d == MODE_OFF) begin
      lane_q <= '0;
      bw_q   <= '0;
      err_q  <= 1'b0;
    end else if (st_q == MODE_OFF) begin
      lane_q <= lane_sel_i;
      bw_q   <= pll_bw_i;
      err_q  <= (lane_sel_i == LANE_BAD);
    end
  end

  assign mode_o      = st_q;
  assign core_rst_no = run_q;
  assign out_en_o    = (st_q == MODE_RUN) && lock_done;
  assign lane_cfg_o  = lane_q;
  assign bw_cfg_o    = bw_q;
  assign cfg_err_o   = err_q;
endmodule

// File: rtl/rx_pwr_mode_ctrl_chk.sv
`timescale 1ns/1ps
module rx_pwr_mode_ctrl_chk #(
  parameter int LOCK_CYC = 1024,
  parameter int BW_W     = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [1:0]      mode_i,
  input logic            core_rst_ni,
  input logic            out_en_i,
  input logic [1:0]      lane_cfg_i,
  input logic [BW_W-1:0] bw_cfg_i,
  input logic            cfg_err_i
);
  localparam logic [1:0] M_OFF = 2'b00;
  localparam logic [1:0] M_RUN = 2'b10;
  localparam int CW = $clog2(LOCK_CYC + 2);
  localparam logic [CW-1:0] CMAX = CW'(LOCK_CYC + 1);
  localparam logic [CW-1:0] CLCK = CW'(LOCK_CYC);

  logic [CW-1:0] run_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                run_cnt_q <= '0;
    else if (mode_i != M_RUN)   run_cnt_q <= '0;
    else if (run_cnt_q != CMAX) run_cnt_q <= run_cnt_q + 1'b1;
  end

  p_off_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == M_OFF) |-> (!out_en_i && !core_rst_ni && lane_cfg_i == '0 &&
                           bw_cfg_i == '0 && !cfg_err_i));

  p_off_not_to_run_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == M_OFF) |=> (mode_i != M_RUN));

  p_en_in_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_i |-> (mode_i == M_RUN));

  p_core_rst_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_rst_ni == (mode_i == M_RUN)));

  p_lock_wait_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_en_i) |-> (run_cnt_q == CLCK));

  p_cfg_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != M_OFF) |=> (mode_i == M_OFF || ($stable(lane_cfg_i) && $stable(bw_cfg_i))));

  p_err_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_i |-> (mode_i != M_RUN));
endmodule

bind rx_pwr_mode_ctrl rx_pwr_mode_ctrl_chk #(
  .LOCK_CYC(LOCK_CYC),
  .BW_W    (BW_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_o),
  .core_rst_ni(core_rst_no),
  .out_en_i   (out_en_o),
  .lane_cfg_i (lane_cfg_o),
  .bw_cfg_i   (bw_cfg_o),
  .cfg_err_i  (cfg_err_o)
);

// File: tb/tb_rx_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module tb_rx_pwr_mode_ctrl;
  localparam int DEB  = 4;
  localparam int LOCK = 40;
  localparam int OFF  = 0;
  localparam int IDLE = 1;
  localparam int RUN  = 2;
  localparam int SHD_LAT  = 3;
  localparam int LINK_LAT = DEB + 3;

  logic clk = 1'b0;
  logic rst_n, shdn_n, link;
  logic [1:0] lane, bw;
  logic [1:0] mode;
  logic core_rst_n, out_en, cfg_err;
  logic [1:0] lane_cfg, bw_cfg;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  rx_pwr_mode_ctrl #(.DEB_CYC(DEB), .LOCK_CYC(LOCK), .BW_W(2)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .shdn_ni    (shdn_n),
    .link_det_i (link),
    .lane_sel_i (lane),
    .pll_bw_i   (bw),
    .mode_o     (mode),
    .core_rst_no(core_rst_n),
    .out_en_o   (out_en),
    .lane_cfg_o (lane_cfg),
    .bw_cfg_o   (bw_cfg),
    .cfg_err_o  (cfg_err)
  );

  task automatic chk_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_mode(input int want, output int n);
    n = 0;
    do begin
      @(posedge clk); n++; @(negedge clk);
    end while (int'(mode) != want && n < 500);
  endtask

  task automatic wait_en(output int n);
    n = 0;
    do begin
      @(posedge clk); n++; @(negedge clk);
    end while (!out_en && n < 500);
  endtask

  task automatic t_reset;
    chk_eq("R1 reset mode", mode, OFF);
    chk_eq("R1 reset outputs", {core_rst_n, out_en, cfg_err, lane_cfg, bw_cfg}, 0);
  endtask

  task automatic t_release;
    int n;
    lane = 2'b01; bw = 2'b10;
    @(negedge clk) shdn_n = 1'b1;
    wait_mode(IDLE, n);
    chk_eq("R2 release latency", n, SHD_LAT);
    chk_eq("R2 idle keeps outputs off", {out_en, core_rst_n}, 0);
    chk_eq("R6 lane captured", lane_cfg, 1);
    chk_eq("R6 bw captured", bw_cfg, 2);
  endtask

  task automatic t_glitch;
    int saw = 0;
    @(negedge clk) link = 1'b1;
    @(negedge clk);
    @(negedge clk) link = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (int'(mode) == RUN) saw = 1;
    end
    chk_eq("R3 short link pulse ignored", saw, 0);
  endtask

  task automatic t_link_up;
    int n;
    @(negedge clk) link = 1'b1;
    wait_mode(RUN, n);
    chk_eq("R3 link to run latency", n, LINK_LAT);
    chk_eq("R4 core released in run", core_rst_n, 1);
    chk_eq("R4 enable waits for lock", out_en, 0);
    wait_en(n);
    chk_eq("R4 lock wait length", n, LOCK);
  endtask

  task automatic t_cfg_hold;
    lane = 2'b11; bw = 2'b01;
    repeat (6) @(negedge clk);
    chk_eq("R6 lane held", lane_cfg, 1);
    chk_eq("R6 bw held", bw_cfg, 2);
    chk_eq("R6 no error from late change", cfg_err, 0);
    chk_eq("R6 still in run", mode, RUN);
  endtask

  task automatic t_link_down;
    int n;
    @(negedge clk) link = 1'b0;
    wait_mode(IDLE, n);
    chk_eq("R5 link loss latency", n, LINK_LAT);
    chk_eq("R5 enable dropped", out_en, 0);
    chk_eq("R5 core back in reset", core_rst_n, 0);
  endtask

  task automatic t_shutdown;
    int n;
    @(negedge clk) shdn_n = 1'b0;
    wait_mode(OFF, n);
    chk_eq("R1 shutdown latency", n, SHD_LAT);
    chk_eq("R1 config cleared", {lane_cfg, bw_cfg, cfg_err}, 0);
  endtask

  task automatic t_relaunch;
    int n;
    link = 1'b1; lane = 2'b10; bw = 2'b01;
    @(negedge clk) shdn_n = 1'b1;
    wait_mode(RUN, n);
    chk_eq("R3 run after release with link up", n, LINK_LAT);
    chk_eq("R6 new lane captured", lane_cfg, 2);
    @(negedge clk) link = 1'b0;
    wait_mode(IDLE, n);
    chk_eq("R5 back to idle", n, LINK_LAT);
  endtask

  task automatic t_collide;
    int saw = 0;
    int first_off = 0;
    @(negedge clk) link = 1'b1;
    repeat (DEB) @(posedge clk);
    @(negedge clk) shdn_n = 1'b0;
    for (int i = 1; i <= 20; i++) begin
      @(posedge clk); @(negedge clk);
      if (int'(mode) == RUN) saw = 1;
      if (int'(mode) == OFF && first_off == 0) first_off = i;
    end
    chk_eq("R8 run never entered", saw, 0);
    chk_eq("R8 shutdown wins edge", first_off, SHD_LAT);
  endtask

  task automatic t_cfg_err;
    int n;
    int saw = 0;
    lane = 2'b11; bw = 2'b00;
    @(negedge clk) shdn_n = 1'b1;
    wait_mode(IDLE, n);
    chk_eq("R7 idle on bad code", n, SHD_LAT);
    chk_eq("R7 error flag", cfg_err, 1);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (int'(mode) != IDLE) saw = 1;
    end
    chk_eq("R7 held in idle with link", saw, 0);
    @(negedge clk) shdn_n = 1'b0;
    wait_mode(OFF, n);
    chk_eq("R7 flag cleared in off", cfg_err, 0);
  endtask

  initial begin
    rst_n = 1'b0; shdn_n = 1'b0; link = 1'b0; lane = 2'b00; bw = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_release();
    t_glitch();
    t_link_up();
    t_cfg_hold();
    t_link_down();
    t_shutdown();
    t_relaunch();
    t_collide();
    t_cfg_err();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule